// File: doc/BRIEF.md
# Masked Associative Word Store

This block is a small content-addressable store of `WORDS` entries, each `WIDTH` bits wide. A search presents an argument and a bit mask. Every occupied entry whose enabled bit positions equal the argument is marked in a hit vector, and that vector is held for readout. When several entries hit, the caller steps through them one per command, from the lowest index to the highest. The current entry's content and index are shown on the output, together with a flag that marks the final hit.

Each entry carries an occupancy bit. Insert places a word in the lowest-numbered free entry, and delete frees an entry by index. An addressed load writes any entry directly, like an ordinary RAM, so that a table can be filled in bulk. Free entries never take part in a search. A flag reports a search that found nothing, and a second flag reports an insert that found no room.

Top module: `assoc_cam_top`

## Requirements
- R1: After synchronous reset every entry is free, `out_valid`, `out_last`, `no_match` and `full` are low, and `out_data` is zero.
- R2: A search compares only the bit positions where `arg_mask` is 1. With an all-zero mask, every occupied entry hits.
- R3: An entry whose occupancy bit is 0 never hits, even when its stored content equals the argument under the mask.
- R4: The result appears in the cycle after a search command. `out_valid` is high if any entry hit, and `out_index`/`out_data` show the lowest-indexed hit.
- R5: Each next command drops the hit being shown, so hits appear in ascending index order. `out_last` is high exactly while one hit remains. After the last hit is dropped, `out_valid` falls. A next command with no hits pending has no effect.
- R6: `no_match` rises in the cycle after a search that hits nothing. It stays high through next and idle commands, and an insert, delete or load clears it.
- R7: Insert writes `arg_data` into the lowest-indexed free entry and marks that entry occupied.
- R8: Insert with no free entry sets `full` and changes no entry. A successful insert clears `full`.
- R9: Delete frees the entry at `cmd_addr`. That entry stops hitting, and it becomes a candidate for the next insert.
- R10: Load writes `arg_data` into the entry at `cmd_addr` and marks it occupied, overwriting any earlier content.
- R11: Insert, delete and load discard any pending search result, so `out_valid` is low in the cycle after them.
- R12: `cmd_op` encodings are 0 idle, 1 search, 2 insert, 3 delete, 4 load and 5 next. The values 6 and 7, and any cycle with `cmd_valid` low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R12) |
| cmd_addr | input | $clog2(WORDS) | Entry index for delete and load |
| arg_data | input | WIDTH | Search argument, or word to store |
| arg_mask | input | WIDTH | Search mask; 1 = compare this bit |
| out_data | output | WIDTH | Content of the current hit, zero when none |
| out_index | output | $clog2(WORDS) | Index of the current hit |
| out_valid | output | 1 | A hit is being presented |
| out_last | output | 1 | The presented hit is the final one |
| no_match | output | 1 | The last search found nothing |
| full | output | 1 | The last insert found no free entry |

## Verification
A corrupted occupancy bit shows up within one search. Either a freed entry appears among the hits, or a filled entry is missing when the mask is all zero, and the entry chosen by the next insert moves. A wrong hit vector shows up in the cycle after the search as a wrong first index or data, or as a wrong `out_last`. A fault in the step logic shows up at the next step as a skipped or repeated index, or as `out_valid` staying high too long. A stale `full` or `no_match` flag can be seen in the cycle after the command that should have changed it.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_SEARCH = 3'd1,
        OP_INSERT = 3'd2,
        OP_DELETE = 3'd3,
        OP_LOAD   = 3'd4,
        OP_NEXT   = 3'd5
    } cam_op_e;

    // write control passed from the command decoder to the storage array
    typedef struct packed {
        logic write;
        logic set_tag;
        logic clr_tag;
    } cam_wr_ctl_t;

endpackage

// File: rtl/cam_first_one.sv
module cam_first_one #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    // lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    assign found = |vec;
endmodule

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  cam_wr_ctl_t        wr,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [WIDTH-1:0]   arg,
    input  logic [WIDTH-1:0]   mask,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WIDTH-1:0]   rd_data,
    output logic [WORDS-1:0]   hit_vec,
    output logic [WORDS-1:0]   tags
);
    logic [WIDTH-1:0] words_q [WORDS];
    logic [WORDS-1:0] tags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tags_q <= '0;
            for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
        end else if (wr.write) begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_idx == IDX_W'(w)) begin
                    words_q[w] <= wr_data;
                    if (wr.set_tag) tags_q[w] <= 1'b1;
                    if (wr.clr_tag) tags_q[w] <= 1'b0;
                end
            end
        end
    end

    // one masked comparator per entry, gated by occupancy
    for (genvar g = 0; g < WORDS; g++) begin : g_cmp
        assign hit_vec[g] = tags_q[g] && (((words_q[g] ^ arg) & mask) == '0);
    end

    assign rd_data = words_q[rd_idx];
    assign tags    = tags_q;
endmodule

// File: rtl/assoc_cam_top.sv
module assoc_cam_top
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_addr,
    input  logic [WIDTH-1:0] arg_data,
    input  logic [WIDTH-1:0] arg_mask,
    output logic [WIDTH-1:0] out_data,
    output logic [IDX_W-1:0] out_index,
    output logic             out_valid,
    output logic             out_last,
    output logic             no_match,
    output logic             full
);
    cam_op_e          op;
    cam_wr_ctl_t      wr;
    logic [IDX_W-1:0] wr_idx;
    logic [WIDTH-1:0] wr_data;
    logic [WIDTH-1:0] rd_data;
    logic [WORDS-1:0] hit_vec, tags, match_q;
    logic [IDX_W-1:0] free_idx, hit_idx;
    logic             free_found, hit_found;
    logic             nomatch_q, full_q;

    assign op = cam_op_e'(cmd_op);

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst(rst), .wr(wr), .wr_idx(wr_idx), .wr_data(wr_data),
        .arg(arg_data), .mask(arg_mask), .rd_idx(hit_idx), .rd_data(rd_data),
        .hit_vec(hit_vec), .tags(tags)
    );

    cam_first_one #(.N(WORDS)) u_free (
        .vec(~tags), .idx(free_idx), .found(free_found)
    );

    cam_first_one #(.N(WORDS)) u_hit (
        .vec(match_q), .idx(hit_idx), .found(hit_found)
    );

    always_comb begin
        wr      = '0;
        wr_idx  = cmd_addr;
        wr_data = arg_data;
        if (cmd_valid) begin
            unique case (op)
                OP_INSERT: if (free_found) begin
                    wr.write   = 1'b1;
                    wr.set_tag = 1'b1;
                    wr_idx     = free_idx;
                end
                OP_DELETE: begin
                    wr.write   = 1'b1;
                    wr.clr_tag = 1'b1;
                    wr_data    = '0;
                end
                OP_LOAD: begin
                    wr.write   = 1'b1;
                    wr.set_tag = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q   <= '0;
            nomatch_q <= 1'b0;
            full_q    <= 1'b0;
        end else if (cmd_valid) begin
            unique case (op)
                OP_SEARCH: begin
                    match_q   <= hit_vec;
                    nomatch_q <= (hit_vec == '0);
                end
                OP_INSERT: begin
                    match_q   <= '0;
                    nomatch_q <= 1'b0;
                    full_q    <= !free_found;
                end
                OP_DELETE, OP_LOAD: begin
                    match_q   <= '0;
                    nomatch_q <= 1'b0;
                end
                OP_NEXT: match_q <= match_q & (match_q - WORDS'(1));
                default: ;
            endcase
        end
    end

    assign out_valid = hit_found;
    assign out_index = hit_idx;
    assign out_data  = hit_found ? rd_data : '0;
    assign out_last  = hit_found && ((match_q & (match_q - WORDS'(1))) == '0);
    assign no_match  = nomatch_q;
    assign full      = full_q;

    p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    p_next_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_NEXT && out_valid) |=>
        ($countones(match_q) == $past($countones(match_q)) - 1));

    p_nomatch_excl_r6: assert property (@(posedge clk) disable iff (rst)
        no_match |-> !out_valid);

    p_hits_active_r3: assert property (@(posedge clk) disable iff (rst)
        (match_q & ~tags) == '0);

    p_search_result_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_SEARCH) |=> (out_valid != no_match));

    p_insert_one_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_INSERT && tags != '1) |=>
        ($countones(tags) == $past($countones(tags)) + 1));

    p_full_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_INSERT && tags == '1) |=> ($stable(tags) && full));

    p_write_drops_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (op == OP_DELETE || op == OP_LOAD)) |=> !out_valid);
endmodule

// File: tb/assoc_cam_top_bench.sv
module assoc_cam_top_bench;
    localparam int WORDS = 8;
    localparam int WIDTH = 16;
    localparam int IDX_W = $clog2(WORDS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [IDX_W-1:0] cmd_addr = '0;
    logic [WIDTH-1:0] arg_data = '0;
    logic [WIDTH-1:0] arg_mask = '0;
    logic [WIDTH-1:0] out_data;
    logic [IDX_W-1:0] out_index;
    logic             out_valid, out_last, no_match, full;

    always #10 clk = ~clk;

    assoc_cam_top #(.WORDS(WORDS), .WIDTH(WIDTH)) u_assoc_cam_top (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .arg_data(arg_data), .arg_mask(arg_mask),
        .out_data(out_data), .out_index(out_index), .out_valid(out_valid),
        .out_last(out_last), .no_match(no_match), .full(full)
    );

    typedef struct {
        logic             v;
        logic [WIDTH-1:0] d;
        logic [IDX_W-1:0] i;
        logic             l;
        logic             nm;
        logic             fl;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 0;

    // reference model built from the requirements
    logic [WIDTH-1:0] m_mem [WORDS];
    logic [WORDS-1:0] m_tag = '0, m_match = '0;
    logic             m_nm = 1'b0, m_full = 1'b0;

    initial for (int w = 0; w < WORDS; w++) m_mem[w] = '0;

    task automatic step(input logic [2:0] op, input int addr,
                        input logic [WIDTH-1:0] arg, input logic [WIDTH-1:0] mask,
                        input string tag);
        exp_t e;
        int   fi;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = IDX_W'(addr);
        arg_data  = arg;
        arg_mask  = mask;
        case (op)
            3'd1: begin
                m_match = '0;
                for (int w = 0; w < WORDS; w++)
                    if (m_tag[w] && (((m_mem[w] ^ arg) & mask) == '0)) m_match[w] = 1'b1;
                m_nm = (m_match == '0);
            end
            3'd2: begin
                fi = -1;
                for (int w = WORDS - 1; w >= 0; w--) if (!m_tag[w]) fi = w;
                if (fi >= 0) begin
                    m_mem[fi] = arg; m_tag[fi] = 1'b1; m_full = 1'b0;
                end else m_full = 1'b1;
                m_match = '0; m_nm = 1'b0;
            end
            3'd3: begin
                m_tag[addr] = 1'b0; m_mem[addr] = '0;
                m_match = '0; m_nm = 1'b0;
            end
            3'd4: begin
                m_mem[addr] = arg; m_tag[addr] = 1'b1;
                m_match = '0; m_nm = 1'b0;
            end
            3'd5: if (m_match != '0) m_match = m_match & (m_match - WORDS'(1));
            default: ;
        endcase
        e.v = (m_match != '0);
        e.i = '0;
        for (int w = WORDS - 1; w >= 0; w--) if (m_match[w]) e.i = IDX_W'(w);
        e.d   = e.v ? m_mem[e.i] : '0;
        e.l   = e.v && ($countones(m_match) == 1);
        e.nm  = m_nm;
        e.fl  = m_full;
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
    endtask

    // monitor: compare each expected item after its command's edge
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                compared++;
                if (out_valid !== e.v || out_data !== e.d || out_last !== e.l ||
                    no_match !== e.nm || full !== e.fl || (e.v && out_index !== e.i)) begin
                    mismatched++;
                    $display("FAIL %s: got v=%b d=%h i=%0d l=%b nm=%b full=%b exp v=%b d=%h i=%0d l=%b nm=%b full=%b",
                             e.tag, out_valid, out_data, out_index, out_last, no_match, full,
                             e.v, e.d, e.i, e.l, e.nm, e.fl);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(3'd0, 0, 16'h0000, 16'h0000, "R1 reset state");
        step(3'd6, 0, 16'h1234, 16'hFFFF, "R12 reserved code");
        step(3'd2, 0, 16'h1234, 16'h0000, "R7 insert slot0");
        step(3'd2, 0, 16'h12AB, 16'h0000, "R7 insert slot1");
        step(3'd2, 0, 16'h5634, 16'h0000, "R7 insert slot2");
        step(3'd2, 0, 16'hFFFF, 16'h0000, "R7 insert slot3");
        step(3'd1, 0, 16'h1200, 16'hFF00, "R2 R4 upper-byte search");
        step(3'd5, 0, 16'h0000, 16'h0000, "R5 next to second hit");
        step(3'd5, 0, 16'h0000, 16'h0000, "R5 next past last");
        step(3'd5, 0, 16'h0000, 16'h0000, "R5 next with none pending");
        step(3'd1, 0, 16'h0034, 16'h00FF, "R2 lower-byte search");
        step(3'd0, 0, 16'h0000, 16'h0000, "R12 idle holds result");
        step(3'd1, 0, 16'h0000, 16'h0000, "R3 zero mask skips free");
        step(3'd5, 0, 16'h0000, 16'h0000, "R5 ascending 1");
        step(3'd5, 0, 16'h0000, 16'h0000, "R5 ascending 2");
        step(3'd5, 0, 16'h0000, 16'h0000, "R5 ascending 3");
        step(3'd5, 0, 16'h0000, 16'h0000, "R5 drained");
        step(3'd1, 0, 16'h9999, 16'hFFFF, "R6 search miss");
        step(3'd5, 0, 16'h0000, 16'h0000, "R6 next keeps flag");
        step(3'd2, 0, 16'h7777, 16'h0000, "R6 insert clears flag");
        step(3'd3, 1, 16'h0000, 16'h0000, "R9 delete slot1");
        step(3'd1, 0, 16'h12AB, 16'hFFFF, "R9 deleted word absent");
        step(3'd2, 0, 16'hAAAA, 16'h0000, "R9 insert reuses slot1");
        step(3'd1, 0, 16'hAAAA, 16'hFFFF, "R9 reused slot found");
        step(3'd4, 7, 16'h0BEE, 16'h0000, "R10 load slot7");
        step(3'd4, 0, 16'h4321, 16'h0000, "R10 load overwrite slot0");
        step(3'd1, 0, 16'h4321, 16'hFFFF, "R10 loaded word found");
        step(3'd1, 0, 16'h1234, 16'hFFFF, "R10 old word gone");
        step(3'd1, 0, 16'h0BEE, 16'hFFFF, "R10 loaded slot7 active");
        step(3'd2, 0, 16'h0505, 16'h0000, "R7 fill slot5");
        step(3'd2, 0, 16'h0606, 16'h0000, "R7 fill slot6");
        step(3'd2, 0, 16'hDEAD, 16'h0000, "R8 insert when full");
        step(3'd1, 0, 16'hDEAD, 16'hFFFF, "R8 rejected word absent");
        step(3'd3, 3, 16'h0000, 16'h0000, "R9 delete slot3");
        step(3'd2, 0, 16'hBEEF, 16'h0000, "R8 insert clears full");
        step(3'd1, 0, 16'h0000, 16'h0000, "R4 all-entry search");
        step(3'd4, 2, 16'h2222, 16'h0000, "R11 load drops result");
        step(3'd1, 0, 16'h0000, 16'h0000, "R4 search again");
        step(3'd3, 4, 16'h0000, 16'h0000, "R11 delete drops result");
        step(3'd1, 0, 16'h0000, 16'h0000, "R3 mask zero after delete");
        step(3'd7, 2, 16'h0000, 16'h0000, "R12 code 7 no effect");
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule